// File: doc/BRIEF.md
# Multi-Channel Sampled Debouncer

This block turns several bouncy one-bit inputs, such as pushbuttons or mechanical switches that are already synchronous to the clock, into steady levels. One free-running interval timer produces a single-cycle sample pulse every `SAMPLE_INTERVAL` clocks, and every channel uses that same pulse. Between pulses the inputs are not looked at, so bounce shorter than an interval cannot register.

Each channel keeps a small saturating counter. On a sample pulse with the input high, the counter advances by one until it reaches `SAT_COUNT`, where it stops. On a sample pulse with the input low, it returns to zero. The registered output of the channel is high exactly while the counter sits at `SAT_COUNT`. A press is therefore reported after `SAT_COUNT` consecutive high samples, and a release is reported at the first low sample.

The inputs and outputs are plain levels with no handshake, because they carry no data stream. `NUM_CH`, `SAMPLE_INTERVAL` (2 or more) and `SAT_COUNT` (1 or more) are parameters. The timer width is ceil(log2(SAMPLE_INTERVAL)). The counter width is ceil(log2(SAT_COUNT+1)).

Top module: `sample_debounce`

## Requirements
- R1: While `rst_n` is low, and after it is released, the timer and every counter start at zero, so every bit of `clean_o` is 0 until a channel saturates.
- R2: Counting the rising clock edges after `rst_n` rises as 1, 2, 3 and so on, an edge n applies a sample pulse exactly when n-1 is a positive multiple of `SAMPLE_INTERVAL`. The pulse is one cycle wide and is shared by all channels.
- R3: On a sampling edge where its input is 1, a channel's counter increments. Once it reaches `SAT_COUNT` it holds there on further high samples, so the output rises on the `SAT_COUNT`-th consecutive high sample.
- R4: `clean_o[i]` rises only at a sampling edge where `noisy_i[i]` is 1. It is 1 exactly while that channel's counter equals `SAT_COUNT`.
- R5: A sampling edge where the input is 0 clears the counter to zero. A high run shorter than `SAT_COUNT` samples therefore never raises the output, and the next attempt again needs `SAT_COUNT` full samples.
- R6: Input values between sampling edges have no effect. An input that toggles freely but is 0 at every sampling edge keeps its output at 0.
- R7: A saturated channel's output stays 1 for as long as its input is 1 at the sampling edges.
- R8: After the input falls, the output goes to 0 at the first sampling edge that sees the low input. This is at most `SAMPLE_INTERVAL`+1 clocks after the fall.
- R9: Channels are independent. Activity on one input changes no other channel's output.
- R10: The counter never exceeds `SAT_COUNT` and the timer never reaches `SAMPLE_INTERVAL`, however long an input is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| noisy_i | input | NUM_CH | Raw levels, already synchronous to `clk` |
| clean_o | output | NUM_CH | Registered debounced levels |

## Verification
The bench aims at the exact sampling edge of the first rise after reset. A design whose timer phase is off by one, or whose output is delayed by an extra register, shows up there as a rise one cycle late or one interval late. It drives a high run that drops one sample before saturation and then retries. A counter that fails to clear on a low sample would make the retry rise early. It toggles an input every cycle while keeping it low at every sampling edge, which catches logic that samples on every clock. It also holds an input high for many intervals, which catches counter wrap-around, and it checks the release edge and that quiet channels stay low while a neighbour is busy.

// File: rtl/sd_pkg.sv
package sd_pkg;
  // Bits needed to hold values 0..max_value, never less than 1.
  function automatic int width_for(input int max_value);
    int w;
    w = $clog2(max_value + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/sd_strobe_timer.sv
module sd_strobe_timer #(
  parameter int SAMPLE_INTERVAL = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o
);
  localparam int TW = sd_pkg::width_for(SAMPLE_INTERVAL - 1);
  localparam logic [TW-1:0] LAST = TW'(SAMPLE_INTERVAL - 1);

  logic [TW-1:0] tick_q;
  logic          strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      tick_q   <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
      strobe_q <= (tick_q == LAST);
    end
  end

  assign strobe_o = strobe_q;

  assert_timer_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= LAST);
  assert_strobe_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (tick_q == '0));
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
endmodule

// File: rtl/sd_channel.sv
module sd_channel #(
  parameter int SAT_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic level_i,
  output logic level_o
);
  localparam int CW = sd_pkg::width_for(SAT_COUNT);
  localparam logic [CW-1:0] TOP = CW'(SAT_COUNT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q;

  always_comb begin
    cnt_d = cnt_q;
    if (strobe_i) begin
      if (!level_i)          cnt_d = '0;
      else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= (cnt_d == TOP);
    end
  end

  assign level_o = out_q;

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(cnt_q) && $stable(out_q));
  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && level_i && cnt_q == TOP) |=> cnt_q == TOP);
  assert_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !level_i) |=> cnt_q == '0);
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(strobe_i) && $past(level_i)));
  assert_stay_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && level_i) |=> out_q);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !level_i) |=> !out_q);
endmodule

// File: rtl/sample_debounce.sv
module sample_debounce #(
  parameter int NUM_CH          = 2,
  parameter int SAMPLE_INTERVAL = 5,
  parameter int SAT_COUNT       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] noisy_i,
  output logic [NUM_CH-1:0] clean_o
);
  logic sample_strobe;

  sd_strobe_timer #(.SAMPLE_INTERVAL(SAMPLE_INTERVAL)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_o (sample_strobe)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sd_channel #(.SAT_COUNT(SAT_COUNT)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (sample_strobe),
      .level_i  (noisy_i[c]),
      .level_o  (clean_o[c])
    );
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> clean_o == '0);
endmodule

// File: tb/sample_debounce_test.sv
module sample_debounce_test;
  localparam int CH = 3;
  localparam int IV = 5;
  localparam int SC = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [CH-1:0] raw;
  logic [CH-1:0] clean;

  sample_debounce #(.NUM_CH(CH), .SAMPLE_INTERVAL(IV), .SAT_COUNT(SC)) uut (
    .clk(clk), .rst_n(rst_n), .noisy_i(raw), .clean_o(clean)
  );

  int checks = 0;
  int fails  = 0;
  int edge_n = 0;
  int mcnt [CH];
  string tag = "R1";
  logic [CH-1:0] exp_q [$];
  string         tag_q [$];

  function automatic bit sample_edge(input int n);
    return (n >= 2) && (((n - 1) % IV) == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // Driver: applies one cycle of input, predicts the output after the edge.
  task automatic step(input logic [CH-1:0] v);
    logic [CH-1:0] e;
    raw = v;
    edge_n++;
    for (int c = 0; c < CH; c++) begin
      if (sample_edge(edge_n)) mcnt[c] = v[c] ? ((mcnt[c] < SC) ? mcnt[c] + 1 : SC) : 0;
      e[c] = (mcnt[c] == SC);
    end
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Steps until k sampling edges have been applied with vector v.
  task automatic run_samples(input logic [CH-1:0] v, input int k);
    int got = 0;
    while (got < k) begin
      if (sample_edge(edge_n + 1)) got++;
      step(v);
    end
  endtask

  // Monitor: compares the design's outputs with the queued predictions.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [CH-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(clean === e, t, int'(clean), int'(e));
    end
  end

  bit done = 1'b0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int first_rise;
    int drop_edge;
    int fall_edge;
    int want_fall;
    bit ch1_seen;
    for (int c = 0; c < CH; c++) mcnt[c] = 0;
    rst_n = 1'b0;
    raw   = '0;
    repeat (3) @(negedge clk);
    chk(clean == '0, "R1 in reset", int'(clean), 0);
    rst_n = 1'b1;

    // R1: outputs stay low after release with idle inputs
    tag = "R1";
    repeat (3) step('0);
    edge_n = edge_n; // phase continues

    // R2/R4: ch0 held high; predicted rise edge from the sampling schedule
    tag = "R2";
    first_rise = -1;
    begin
      int want_rise = -1;
      int seen = 0;
      for (int n = edge_n + 1; n < 200 && want_rise < 0; n++)
        if (sample_edge(n)) begin seen++; if (seen == SC) want_rise = n; end
      for (int i = 0; i < 30; i++) begin
        step(3'b001);
        if (clean[0] && first_rise < 0) first_rise = edge_n;
      end
      chk(first_rise == want_rise, "R2 R4 rise edge", first_rise, want_rise);
    end

    // R7/R10: ch0 stays high for many intervals; no wrap of the counter
    tag = "R7";
    run_samples(3'b001, 12);
    chk(clean[0] == 1'b1, "R7 R10 still high", int'(clean[0]), 1);

    // R8: release of ch0
    tag = "R8";
    step(3'b000);
    drop_edge = edge_n;
    want_fall = drop_edge;
    while (!sample_edge(want_fall)) want_fall++;
    fall_edge = clean[0] ? -1 : edge_n;
    for (int i = 0; i < IV + 1 && fall_edge < 0; i++) begin
      step(3'b000);
      if (!clean[0]) fall_edge = edge_n;
    end
    chk(fall_edge == want_fall, "R8 fall edge", fall_edge, want_fall);
    chk((fall_edge - drop_edge) <= IV, "R8 bound", fall_edge - drop_edge, IV);

    // R6/R9: ch1 toggles but is low at each sampling edge; ch2 held high
    tag = "R6";
    ch1_seen = 1'b0;
    for (int i = 0; i < 8 * IV; i++) begin
      logic b1;
      b1 = sample_edge(edge_n + 1) ? 1'b0 : logic'(i % 2);
      step({1'b1, b1, 1'b0});
      if (clean[1]) ch1_seen = 1'b1;
    end
    chk(!ch1_seen, "R6 toggle ignored", int'(ch1_seen), 0);
    chk(clean[2] == 1'b1, "R9 ch2 rose beside activity", int'(clean[2]), 1);
    chk(clean[0] == 1'b0, "R9 ch0 quiet", int'(clean[0]), 0);

    // R5/R3: ch1 short run then retry needs full count
    tag = "R5";
    run_samples(3'b110, SC - 1);
    run_samples(3'b100, 1);
    chk(clean[1] == 1'b0, "R5 short run", int'(clean[1]), 0);
    tag = "R3";
    run_samples(3'b110, SC - 1);
    chk(clean[1] == 1'b0, "R3 R5 before full count", int'(clean[1]), 0);
    run_samples(3'b110, 1);
    chk(clean[1] == 1'b1, "R3 at full count", int'(clean[1]), 1);
    run_samples(3'b110, 3);
    chk(clean[1] == 1'b1, "R3 hold at top", int'(clean[1]), 1);
    tag = "R9";
    run_samples(3'b010, 1);
    chk(clean == 3'b010, "R9 ch2 release only", int'(clean), 2);
    repeat (3) step(3'b000);

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule